// File: doc/BRIEF.md
# ALU Control Decoder with Shift-Capable Arithmetic Unit

This block combines a 32-bit arithmetic and logic unit with the small decoder that chooses its operation. A two-bit operation class from the main control and the six-bit function field of the instruction together pick one internal operation. The available operations are add, subtract, bitwise AND, bitwise OR, signed set-less-than, and shift left logical by a five-bit amount. A fixed 16-bit left shift of the second operand serves load-upper-immediate.

Operand selection and sign extension happen upstream. The block receives two ready-made 32-bit operands and the shift-amount field taken from instruction bits 10 to 6. It returns a 32-bit result and a zero flag, which the branch logic uses after a subtraction. The result and the flag are registered, so each one appears one clock after its operands are presented.

Top module: `alu_unit`

## Requirements
- R1: With operation class 2'b00 the result is opnd_a + opnd_b, for any function field and shift amount.
- R2: With operation class 2'b01 the result is opnd_a - opnd_b, for any function field and shift amount.
- R3: With operation class 2'b10 the function field selects the operation: 6'b100000 adds, 6'b100010 subtracts, 6'b100100 gives a AND b, 6'b100101 gives a OR b, and 6'b101010 gives 32'd1 when opnd_a is less than opnd_b as signed two's-complement numbers and 32'd0 otherwise.
- R4: With operation class 2'b10 and function field 6'b000000 the result is opnd_b shifted left logically by the 5-bit shamt value, with zeros shifted in.
- R5: With operation class 2'b11 the result is opnd_b shifted left by exactly 16 bits, for any function field and shift amount.
- R6: With operation class 2'b10 and any function field not listed in R3 or R4, the result is opnd_a + opnd_b.
- R7: zero is 1 exactly when all 32 bits of result are 0.
- R8: Add and subtract wrap modulo 2^32 and signal no overflow.
- R9: result and zero update on the rising clock edge after the inputs are applied. A synchronous active-high rst sets result to 0 and zero to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 2 | Operation class from the main control |
| funct | input | 6 | Instruction function field |
| shamt | input | 5 | Shift amount, instruction bits 10 to 6 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register or immediate) |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, high when result is all zeros |

## Verification
The assertions assume that every input is at a known value at each rising edge outside reset. The operation-class checks compare the result with the operands from the cycle before, so they also depend on the inputs changing only between edges. The bench drives all inputs at the falling edge and never leaves them undriven. It sweeps all operation classes against all 64 function codes, every shift amount, and random and boundary operands such as equal values, sign-crossing pairs and wraparound sums.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W   = 32;
    localparam int FUNCT_W  = 6;
    localparam int SHAMT_W  = 5;
    localparam int CLASS_W  = 2;
    localparam int UPPER_SH = 16;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FN   = 2'b10,
        CLS_UPR  = 2'b11
    } op_class_e;

    typedef enum logic [3:0] {
        CTL_AND = 4'b0000,
        CTL_OR  = 4'b0001,
        CTL_ADD = 4'b0010,
        CTL_SUB = 4'b0110,
        CTL_SLT = 4'b0111,
        CTL_UPR = 4'b1101,
        CTL_SLL = 4'b1110
    } alu_ctl_e;

    localparam logic [FUNCT_W-1:0] FN_SLL = 6'b000000;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef struct packed {
        alu_ctl_e               ctl;
        logic [SHAMT_W-1:0]     shamt;
        logic [DATA_W-1:0]      a;
        logic [DATA_W-1:0]      b;
    } alu_req_t;

    typedef struct packed {
        logic [DATA_W-1:0]      value;
        logic                   is_zero;
    } alu_rsp_t;

    function automatic logic signed_less(input logic [DATA_W-1:0] x,
                                         input logic [DATA_W-1:0] y);
        return $signed(x) < $signed(y);
    endfunction

endpackage

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
    import alu_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] fn_field,
    output alu_ctl_e           ctl
);

    alu_ctl_e fn_ctl;

    always_comb begin
        case (fn_field)
            FN_SLL:  fn_ctl = CTL_SLL;
            FN_ADD:  fn_ctl = CTL_ADD;
            FN_SUB:  fn_ctl = CTL_SUB;
            FN_AND:  fn_ctl = CTL_AND;
            FN_OR:   fn_ctl = CTL_OR;
            FN_SLT:  fn_ctl = CTL_SLT;
            default: fn_ctl = CTL_ADD;
        endcase
    end

    always_comb begin
        case (op_class_e'(op_class))
            CLS_ADD: ctl = CTL_ADD;
            CLS_SUB: ctl = CTL_SUB;
            CLS_FN:  ctl = fn_ctl;
            CLS_UPR: ctl = CTL_UPR;
            default: ctl = CTL_ADD;
        endcase
    end

endmodule

// File: rtl/alu_shl.sv
module alu_shl #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        if (STEP < WIDTH) begin : g_shift
            assign stage[s+1] = amt[s] ? {stage[s][WIDTH-1-STEP:0], {STEP{1'b0}}}
                                       : stage[s];
        end else begin : g_clear
            assign stage[s+1] = amt[s] ? '0 : stage[s];
        end
    end

    assign dout = stage[AMT_W];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  alu_req_t req,
    output alu_rsp_t rsp
);

    localparam logic [SHAMT_W-1:0] UPPER_AMT = SHAMT_W'(UPPER_SH);

    logic [SHAMT_W-1:0] sh_amt;
    logic [DATA_W-1:0]  sh_out;
    logic [DATA_W-1:0]  sum;
    logic [DATA_W-1:0]  diff;
    logic [DATA_W-1:0]  value;

    assign sh_amt = (req.ctl == CTL_UPR) ? UPPER_AMT : req.shamt;

    alu_shl #(.WIDTH(DATA_W), .AMT_W(SHAMT_W)) u_shl (
        .din  (req.b),
        .amt  (sh_amt),
        .dout (sh_out)
    );

    assign sum  = req.a + req.b;
    assign diff = req.a - req.b;

    always_comb begin
        case (req.ctl)
            CTL_AND: value = req.a & req.b;
            CTL_OR:  value = req.a | req.b;
            CTL_ADD: value = sum;
            CTL_SUB: value = diff;
            CTL_SLT: value = {{(DATA_W-1){1'b0}}, signed_less(req.a, req.b)};
            CTL_SLL: value = sh_out;
            CTL_UPR: value = sh_out;
            default: value = sum;
        endcase
    end

    assign rsp.value   = value;
    assign rsp.is_zero = ~|value;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         alu_op,
    input  logic [5:0]         funct,
    input  logic [4:0]         shamt,
    input  logic [31:0]        opnd_a,
    input  logic [31:0]        opnd_b,
    output logic [31:0]        result,
    output logic               zero
);

    alu_ctl_e ctl;
    alu_req_t req;
    alu_rsp_t rsp;
    alu_rsp_t rsp_q;

    alu_ctl_dec u_dec (
        .op_class (alu_op),
        .fn_field (funct),
        .ctl      (ctl)
    );

    assign req.ctl   = ctl;
    assign req.shamt = shamt;
    assign req.a     = opnd_a;
    assign req.b     = opnd_b;

    alu_core u_core (
        .req (req),
        .rsp (rsp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q.value   <= '0;
            rsp_q.is_zero <= 1'b1;
        end else begin
            rsp_q <= rsp;
        end
    end

    assign result = rsp_q.value;
    assign zero   = rsp_q.is_zero;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  alu_op,
    input logic [5:0]  funct,
    input logic [4:0]  shamt,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] result,
    input logic        zero
);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (result == 32'd0 && zero));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        zero == (result == 32'd0));

    // R1
    class_add_chk: assert property (@(posedge clk) disable iff (rst)
        alu_op == 2'b00 |=> result == $past(opnd_a) + $past(opnd_b));

    // R2
    class_sub_chk: assert property (@(posedge clk) disable iff (rst)
        alu_op == 2'b01 |=> result == $past(opnd_a) - $past(opnd_b));

    // R5
    upper_shift_chk: assert property (@(posedge clk) disable iff (rst)
        alu_op == 2'b11 |=> result == {$past(opnd_b[15:0]), 16'h0000});

    // R4
    sll_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && funct == 6'b000000) |=>
            result == ($past(opnd_b) << $past(shamt)));

    // R3
    slt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && funct == 6'b101010) |=> result[31:1] == 31'd0);

endmodule

bind alu_unit alu_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .alu_op (alu_op),
    .funct  (funct),
    .shamt  (shamt),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .zero   (zero)
);

// File: tb/alu_unit_bench.sv
`timescale 1ns/1ps
module alu_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  alu_op = 2'b00;
    logic [5:0]  funct = 6'd0;
    logic [4:0]  shamt = 5'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_unit u_alu_unit (
        .clk(clk), .rst(rst), .alu_op(alu_op), .funct(funct), .shamt(shamt),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .zero(zero)
    );

    function automatic logic [31:0] model(input logic [1:0] op, input logic [5:0] fn,
                                          input logic [4:0] sh, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [32:0] wide;
        case (op)
            2'b00: begin wide = {1'b0, a} + {1'b0, b}; return wide[31:0]; end
            2'b01: begin wide = {1'b0, a} + {1'b0, ~b} + 33'd1; return wide[31:0]; end
            2'b11: return b * 32'd65536;
            default: begin
                case (fn)
                    6'b000000: return b * (32'd1 << sh);
                    6'b100010: begin wide = {1'b0, a} + {1'b0, ~b} + 33'd1; return wide[31:0]; end
                    6'b100100: return a & b;
                    6'b100101: return a | b;
                    6'b101010: begin
                        if (a[31] != b[31]) return {31'd0, a[31]};
                        return {31'd0, a < b};
                    end
                    default: begin wide = {1'b0, a} + {1'b0, b}; return wide[31:0]; end
                endcase
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input string req, input logic [1:0] op, input logic [5:0] fn,
                       input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e;
        @(negedge clk);
        alu_op = op; funct = fn; shamt = sh; opnd_a = a; opnd_b = b;
        e = model(op, fn, sh, a, b);
        @(posedge clk);
        #1;
        check(req, result, e);
        check("R7", {31'd0, zero}, {31'd0, e == 32'd0});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset result", result, 32'd0);
        check("R9 reset zero", {31'd0, zero}, 32'd1);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6: every class against every function code
        for (int op = 0; op < 4; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                run("R1-6 sweep", 2'(op), 6'(fn), 5'(fn % 32), 32'h8765_4321, 32'h1234_F00F);
            end
        end

        // R4: every shift amount
        for (int s = 0; s < 32; s++) begin
            run("R4 sll", 2'b10, 6'b000000, 5'(s), 32'h0, 32'hA5C3_0F81);
        end

        // R5: shift amount and funct ignored
        for (int s = 0; s < 32; s++) begin
            run("R5 upper", 2'b11, 6'(s * 2 + 1), 5'(s), 32'hFFFF_FFFF, 32'h0001_BEEF);
        end

        // R8 wrap and R7 zero cases
        run("R8 add wrap", 2'b00, 6'h3F, 5'd3, 32'hFFFF_FFFF, 32'd1);
        run("R8 sub wrap", 2'b01, 6'h00, 5'd0, 32'd0, 32'd1);
        run("R2 equal", 2'b01, 6'h20, 5'd0, 32'h1357_9BDF, 32'h1357_9BDF);
        run("R8 fn add wrap", 2'b10, 6'b100000, 5'd0, 32'h8000_0000, 32'h8000_0000);

        // R3 signed compare boundaries
        run("R3 slt neg<pos", 2'b10, 6'b101010, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF);
        run("R3 slt pos>neg", 2'b10, 6'b101010, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000);
        run("R3 slt equal", 2'b10, 6'b101010, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run("R3 slt -2<-1", 2'b10, 6'b101010, 5'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFF);

        // R1 R2 R3 random operands
        for (int i = 0; i < 400; i++) begin
            logic [5:0] fsel [6] = '{6'b100000, 6'b100010, 6'b100100,
                                     6'b100101, 6'b101010, 6'b000000};
            run("R3 random", 2'($urandom_range(0, 3)), fsel[i % 6],
                5'($urandom), $urandom, $urandom);
        end

        // R9 reset mid-run
        @(negedge clk);
        alu_op = 2'b00; opnd_a = 32'd5; opnd_b = 32'd6; rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9 sync reset result", result, 32'd0);
        check("R9 sync reset zero", {31'd0, zero}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R9 after reset", result, 32'd11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule